// File: doc/BRIEF.md
# Eight-bit ALU with packed flag byte

The block is the arithmetic and logic core of an accumulator-based processor. It takes operand A from the accumulator and operand B from a temporary register. A 4-bit operation code selects the operation, and the block forms the 8-bit result combinationally in the same cycle. The result also uses the carry bit already held in the flag register. When the execute strobe `en_i` is high at a rising clock edge, the flag byte is updated.

The flag byte holds five condition bits at fixed positions: sign, zero, auxiliary carry, parity and carry. A separate 16-bit adder adds two register pairs. When `pair_en_i` is strobed, only the carry bit takes the result of that addition, and the other flags keep their values. The output `acc_we_o` tells the surrounding datapath whether the result should be written back to the accumulator.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 8'h00.
- R2: Op codes 0 (add) and 1 (add with carry) give `result_o` = (A + B + c) mod 256, where c is the held CY for code 1 and 0 for code 0. The new CY is the carry out of bit 7. The new AC is the carry out of bit 3 of A[3:0] + B[3:0] + c.
- R3: Op codes 2 (subtract) and 3 (subtract with borrow) give `result_o` = (A - B - w) mod 256, where w is the held CY for code 3 and 0 for code 2. The new CY is 1 when A < B + w. The new AC is the carry out of bit 3 of A[3:0] + (15 - B[3:0]) + (1 - w).
- R4: Op code 4 (compare) sets the flags exactly as op code 2 does, drives the difference on `result_o`, and holds `acc_we_o` low.
- R5: For op codes 0 to 7 and 13, the new flags are set as follows. S is result bit 7. Z is 1 when the result is zero. P is 1 when the result has an even number of ones.
- R6: Op codes 5 (AND), 6 (OR) and 7 (XOR) give the bitwise result and clear CY. AND sets AC, while OR and XOR clear AC.
- R7: Op code 8 gives `result_o` = ~A and leaves every flag unchanged.
- R8: The rotate op codes change only CY:
  - Code 9 rotates left, with bit 7 going to bit 0 and to CY.
  - Code 10 rotates right, with bit 0 going to bit 7 and to CY.
  - Code 11 rotates left through carry: old CY goes to bit 0 and bit 7 goes to CY.
  - Code 12 rotates right through carry: old CY goes to bit 7 and bit 0 goes to CY.
- R9: Op code 13 (decimal adjust) works in three steps:
  - It adds 6 when A[3:0] > 9 or AC is set.
  - It adds 0x60 when A > 0x99 or CY is set.
  - The new CY is the old CY OR (A > 0x99). The new AC is the carry out of bit 3 of that addition.
- R10: `pair_sum_o` is (pair_a_i + pair_b_i) mod 65536. A strobe on `pair_en_i` loads CY with the carry out of bit 15 and keeps flag bits 7..1. `pair_en_i` has priority over `en_i`, and `acc_we_o` is low while it is high.
- R11: The flag layout is S bit 7, Z bit 6, AC bit 4, P bit 2 and CY bit 0. Bits 5, 3 and 1 always read 0.
- R12: With neither strobe high, the flags hold their value. Op codes 14 and 15 give `result_o` = A, keep `acc_we_o` low and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Execute strobe for the 8-bit operation |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Temporary register operand |
| pair_en_i | input | 1 | Strobe for the 16-bit pair addition |
| pair_a_i | input | 16 | First register pair |
| pair_b_i | input | 16 | Second register pair |
| result_o | output | 8 | 8-bit result |
| acc_we_o | output | 1 | Result should be written to the accumulator |
| pair_sum_o | output | 16 | 16-bit pair sum |
| flags_o | output | 8 | Registered flag byte |

## Verification
`result_o`, `acc_we_o` and `pair_sum_o` are combinational and are due in the same cycle as the inputs. The bench samples them one time unit after driving on the falling edge. `flags_o` changes at the first rising edge on which a strobe is high, so it is sampled one time unit after that edge and before the next inputs are driven. The bench keeps its own model of the flag byte, which supplies the carry input for the next operation, so long sweeps run back to back without realignment.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_NOT = 4'd8, OP_RLC = 4'd9, OP_RRC = 4'd10, OP_RAL = 4'd11,
    OP_RAR = 4'd12, OP_DAA = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } alu_op_e;

  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_AC = 4;
  localparam int FL_P  = 2;
  localparam int FL_CY = 0;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8,
  parameter int H = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   full;
  logic [H:0]   low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c0    = sub_i ^ cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    low   = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
    sum_o = full[W-1:0];
    cy_o  = full[W] ^ sub_i;   // borrow is inverted carry
    hc_o  = low[H];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa (
  input  logic [7:0] a_i,
  input  logic       ac_i,
  input  logic       cy_i,
  output logic [7:0] res_o,
  output logic       ac_o,
  output logic       cy_o
);
  logic       fix_lo, fix_hi;
  logic [7:0] corr;
  logic [4:0] low;

  always_comb begin
    fix_lo = ac_i || (a_i[3:0] > 4'd9);
    fix_hi = cy_i || (a_i > 8'h99);
    corr   = {fix_hi ? 4'h6 : 4'h0, fix_lo ? 4'h6 : 4'h0};
    res_o  = a_i + corr;
    low    = {1'b0, a_i[3:0]} + {1'b0, corr[3:0]};
    ac_o   = low[4];
    cy_o   = cy_i || (a_i > 8'h99);
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              pair_en_i,
  input  logic [PAIR_W-1:0] pair_a_i,
  input  logic [PAIR_W-1:0] pair_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [PAIR_W-1:0] pair_sum_o,
  output logic [7:0]        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic [7:0]        flags_q, flags_d;
  logic              sub, cin;
  logic [DATA_W-1:0] add_sum, lg_res, daa_res;
  logic              add_cy, add_hc, lg_cy, daa_ac, daa_cy;
  logic [PAIR_W:0]   pair_full;

  assign op  = alu_op_e'(op_i);
  assign sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign cin = ((op == OP_ADC) || (op == OP_SBB)) && flags_q[FL_CY];

  alu8_adder #(.W(DATA_W), .H(HALF_W)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(sub), .cin_i(cin),
    .sum_o(add_sum), .cy_o(add_cy), .hc_o(add_hc)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .cy_i(flags_q[FL_CY]),
    .res_o(lg_res), .cy_o(lg_cy)
  );

  alu8_daa u_daa (
    .a_i(a_i), .ac_i(flags_q[FL_AC]), .cy_i(flags_q[FL_CY]),
    .res_o(daa_res), .ac_o(daa_ac), .cy_o(daa_cy)
  );

  always_comb begin
    flags_d = flags_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        result_o          = add_sum;
        flags_d[FL_CY]    = add_cy;
        flags_d[FL_AC]    = add_hc;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_o          = lg_res;
        flags_d[FL_CY]    = 1'b0;
        flags_d[FL_AC]    = (op == OP_AND);
      end
      OP_NOT: result_o = lg_res;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result_o          = lg_res;
        flags_d[FL_CY]    = lg_cy;
      end
      OP_DAA: begin
        result_o          = daa_res;
        flags_d[FL_CY]    = daa_cy;
        flags_d[FL_AC]    = daa_ac;
      end
      default: result_o = a_i;
    endcase
    if (op <= OP_XOR || op == OP_DAA) begin
      flags_d[FL_S] = result_o[DATA_W-1];
      flags_d[FL_Z] = (result_o == '0);
      flags_d[FL_P] = ~^result_o;
    end
    flags_d[5] = 1'b0;
    flags_d[3] = 1'b0;
    flags_d[1] = 1'b0;
  end

  assign acc_we_o   = en_i && !pair_en_i &&
                      (op != OP_CMP) && (op != OP_RS14) && (op != OP_RS15);
  assign pair_full  = {1'b0, pair_a_i} + {1'b0, pair_b_i};
  assign pair_sum_o = pair_full[PAIR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= 8'h00;
    else if (pair_en_i) flags_q[FL_CY] <= pair_full[PAIR_W];
    else if (en_i)      flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [3:0] op_i,
  input logic       pair_en_i,
  input logic [7:0] result_o,
  input logic       acc_we_o,
  input logic [7:0] flags_o
);
  logic szp_op;
  assign szp_op = en_i && !pair_en_i && (op_i <= 4'd7 || op_i == 4'd13);

  always_comb begin
    if (rst_ni && op_i == 4'd4)
      a_r4_cmp_no_write: assert (!acc_we_o);
  end

  a_r11_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b0));

  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    szp_op |=> flags_o[6] == ($past(result_o) == 8'h00));

  a_r5_sign_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    szp_op |=> flags_o[7] == $past(result_o[7]));

  a_r6_logic_clears_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pair_en_i && op_i >= 4'd5 && op_i <= 4'd7) |=> !flags_o[0]);

  a_r7_not_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pair_en_i && op_i == 4'd8) |=> $stable(flags_o));

  a_r10_pair_keeps_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_en_i |=> flags_o[7:1] == $past(flags_o[7:1]));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pair_en_i) |=> $stable(flags_o));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
  .pair_en_i(pair_en_i), .result_o(result_o), .acc_we_o(acc_we_o),
  .flags_o(flags_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [7:0]  a = 8'd0, b = 8'd0;
  logic        pair_en = 1'b0;
  logic [15:0] pa = 16'd0, pb = 16'd0;
  logic [7:0]  result;
  logic        acc_we;
  logic [15:0] psum;
  logic [7:0]  flags;

  int total = 0;
  int bad = 0;
  logic [7:0] m_fl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
    .pair_en_i(pair_en), .pair_a_i(pa), .pair_b_i(pb),
    .result_o(result), .acc_we_o(acc_we), .pair_sum_o(psum), .flags_o(flags)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag(input int o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5, 6, 7: return "R6";
      8: return "R7";
      9, 10, 11, 12: return "R8";
      13: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input int o, input int x, input int y, input logic [7:0] fl,
                       output logic [7:0] res, output logic we, output logic [7:0] nf);
    int t, c, cy, ac;
    logic szp;
    cy = fl[0]; ac = fl[4]; nf = fl; szp = 1'b0; we = 1'b1; res = x[7:0];
    case (o)
      0, 1: begin
        c = (o == 1) ? cy : 0;
        t = x + y + c; res = t[7:0];
        cy = (t > 255); ac = ((x % 16) + (y % 16) + c) > 15; szp = 1'b1;
      end
      2, 3, 4: begin
        c = (o == 3) ? cy : 0;
        t = x - y - c; res = t[7:0];
        cy = (t < 0); ac = ((x % 16) + (15 - y % 16) + (1 - c)) > 15; szp = 1'b1;
        if (o == 4) we = 1'b0;
      end
      5: begin res = x & y; cy = 0; ac = 1; szp = 1'b1; end
      6: begin res = x | y; cy = 0; ac = 0; szp = 1'b1; end
      7: begin res = x ^ y; cy = 0; ac = 0; szp = 1'b1; end
      8: res = 8'(255 - x);
      9:  begin res = 8'((x * 2) % 256 + x / 128); cy = x / 128; end
      10: begin res = 8'(x / 2 + (x % 2) * 128); cy = x % 2; end
      11: begin res = 8'((x * 2) % 256 + cy); cy = x / 128; end
      12: begin res = 8'(x / 2 + cy * 128); cy = x % 2; end
      13: begin
        c = 0;
        if (ac == 1 || (x % 16) > 9) c = 6;
        if (cy == 1 || x > 153) begin c = c + 96; cy = 1; end
        ac = ((x % 16) + (c % 16)) > 15;
        t = x + c; res = t[7:0]; szp = 1'b1;
      end
      default: we = 1'b0;
    endcase
    nf[0] = cy[0]; nf[4] = ac[0];
    if (szp) begin
      nf[7] = res[7]; nf[6] = (res == 8'd0); nf[2] = ($countones(res) % 2 == 0);
    end
  endtask

  task automatic run_op(input int o, input int x, input int y);
    logic [7:0] er, ef; logic ew;
    @(negedge clk);
    en = 1'b1; pair_en = 1'b0; op = 4'(o); a = 8'(x); b = 8'(y);
    model(o, x, y, m_fl, er, ew, ef);
    #1;
    check({tag(o), " result"}, result, er);
    check({tag(o), " acc_we"}, acc_we, ew);
    @(posedge clk); #1;
    m_fl = ef;
    if (o <= 7 || o == 13) check({"R5/", tag(o), " flags"}, flags, ef);
    else check({tag(o), " flags"}, flags, ef);
  endtask

  task automatic run_pair(input int x, input int y, input logic with_en);
    int s;
    @(negedge clk);
    pair_en = 1'b1; en = with_en; op = 4'd0; a = 8'hFF; b = 8'hFF;
    pa = 16'(x); pb = 16'(y);
    s = x + y;
    #1;
    check("R10 pair_sum", psum, s % 65536);
    check("R10 acc_we low", acc_we, 0);
    @(posedge clk); #1;
    m_fl[0] = (s > 65535);
    check("R10 pair flags", flags, m_fl);
    @(negedge clk); pair_en = 1'b0; en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check("R1 reset flags", flags, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 flags after release", flags, 0);

    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 256; x++)
        for (int yi = 0; yi < 8; yi++)
          run_op(o, x, (yi == 7) ? 255 : yi * 37);

    // directed decimal adjust corners
    run_op(0, 8'h99, 8'h01);  run_op(13, 8'h9A, 0);
    check("R9 0x99+1 adjusted", result, 8'h00);
    run_op(0, 8'h38, 8'h45);  run_op(13, 8'h7D, 0);
    check("R9 38+45 adjusted", result, 8'h83);

    // idle: no strobe, flags held
    run_op(0, 8'hFF, 8'h01);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); en = 1'b0; op = 4'(k); a = 8'h00; b = 8'h00;
      @(posedge clk); #1;
      check("R12 idle hold", flags, m_fl);
    end

    // pair add, alone and with en_i high
    run_op(5, 8'h80, 8'h80);
    run_pair(16'hFFFF, 16'h0001, 1'b0);
    check("R11 unused bits", flags & 8'h2A, 0);
    run_pair(16'h1234, 16'h0100, 1'b1);
    run_pair(16'h8000, 16'h8000, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule